// File: doc/BRIEF.md
# Serial Configuration Master for an Infrared Transceiver Module

This block sets up an external infrared transceiver through three wires: a clock it drives, a data line it drives, and a data line driven back by the module. The host starts one transaction at a time. It gives an operation code, a device address, a register index and a data byte. The block produces the whole waveform and, for reads, samples the reply. It reports completion with a one-cycle `done`, together with the read byte and a flag that marks a missing reply. Besides single writes and reads, the block can send a long reset burst. It can also run a built-in start-up sequence that programs the module's mode.

All traffic is built from one primitive, the pulse slot. In each slot the clock is held low for `LO_CYC` system cycles and then high for `HI_CYC` cycles. The data line changes only inside the low phase. The returned line passes through a two-flop synchronizer. It is sampled in the last high cycle of a slot, just before the clock falls.

The controller is a state machine with these states:
- `S_IDLE`: leaves on a request, to `S_START`, or to `S_RST` for reset and start-up.
- `S_START`: one pulse with data low.
- `S_CMD`: 8 command pulses. Goes to `S_WDAT` for a write or `S_POLL` for a read.
- `S_WDAT`: 8 data pulses, then `S_WTAIL`.
- `S_WTAIL`: 2 pulses with data low.
- `S_POLL`: at most `POLL_MAX` pulses with data high. Goes to `S_RDAT` when the reply line is low, otherwise to `S_DUMMY`.
- `S_RDAT`: 8 sampled pulses.
- `S_DUMMY`: 2 pulses.
- `S_REND`: 1 pulse with data high.
- `S_RFIN`: 3 pulses with data low.
- `S_RST`: `RST_PULSES` pulses with data low.
- `S_DONE`: one cycle, back to `S_IDLE`.

When `S_WTAIL`, `S_RFIN` or `S_RST` finishes inside the start-up sequence, the controller loads the next step and goes back to `S_START`. Otherwise it goes to `S_DONE`.

Top module: `irx_cfg_master`

## Requirements
- R1: The command byte equals device address OR (index shifted left by one) OR a direction bit in bit 0, where 1 means write and 0 means read. Every byte is sent least significant bit first, one bit per clock pulse.
- R2: The data output never changes while the configuration clock is high.
- R3: A write (`op`=0) sends 19 pulses. The first has data low, then come 8 command bits, then 8 data bits, then 2 pulses with data low. The clock is left low.
- R4: A read (`op`=1) follows the command with pulses that keep data high. It stops polling at the first pulse after which the reply line is low, and never polls more than 10 pulses.
- R5: After ready, a read samples 8 reply bits, least significant bit first, one per pulse. It returns them on `rdata` with `no_resp` = 0.
- R6: When ready is never seen in 10 polls, the read sends 2 extra pulses and returns `rdata` = 0 with `no_resp` = 1.
- R7: Every read ends with one pulse with data high, then three pulses with data low.
- R8: A reset (`op`=2) sends 30 pulses with data low.
- R9: Start-up (`op`=3) runs these steps in order:
  - a reset;
  - writes to address 0x40 of index 0 = 0x17, index 1 = `wdata`, and index 2 = 0xFF;
  - a read of index 1.

  The result of that read is reported.
- R10: `busy` rises the cycle after an accepted request. Requests made while `busy` is high are ignored. `done` is high for exactly one cycle at the end of each transaction.
- R11: After reset and whenever idle, the clock and data outputs are low, `busy` and `done` are low, and `rdata` and `no_resp` reset to 0.
- R12: Every clock high phase lasts `HI_CYC` cycles. Every low phase between two pulses of a transaction lasts `LO_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (accepted only when idle) |
| op | input | 2 | 0 write, 1 read, 2 reset burst, 3 start-up sequence |
| dev_addr | input | 8 | Device address for the command byte |
| reg_idx | input | 7 | Register index for the command byte |
| wdata | input | 8 | Write data, or the mode byte for start-up |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 8 | Last read byte |
| no_resp | output | 1 | Last read saw no ready indication |
| cfg_clk | output | 1 | Clock to the transceiver module |
| cfg_dout | output | 1 | Data to the transceiver module |
| cfg_din | input | 1 | Data/ready from the transceiver module |

## Verification
A wrong bit counter or wrong state shows up at the ports within one pulse slot. The bit seen on `cfg_dout` at the next rising clock differs from the stream predicted from the requirements, or the pulse count of the frame is wrong when `done` arrives. A wrong poll or sample decision only shows at `done`, as a wrong `rdata` or `no_resp` and a frame length off by several pulses. The start-up sequence needs a full chained frame of about 120 pulses before its result can be seen, so any fault inside it is reported only at that `done`.

// File: rtl/irx_pkg.sv
package irx_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_CMD, S_WDAT, S_WTAIL, S_POLL,
        S_RDAT, S_DUMMY, S_REND, S_RFIN, S_RST, S_DONE
    } irx_state_e;

    typedef enum logic [1:0] {
        OP_WR   = 2'd0,
        OP_RD   = 2'd1,
        OP_RST  = 2'd2,
        OP_INIT = 2'd3
    } irx_op_e;
endpackage

// File: rtl/irx_sync2.sv
module irx_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irx_pulse_gen.sv
module irx_pulse_gen #(
    parameter int HI_CYC = 4,
    parameter int LO_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic clk_o,
    output logic slot_end
);
    localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int PW   = $clog2(MAXC + 1);

    logic [PW-1:0] ph_cnt;
    logic          hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            hi     <= 1'b0;
        end else if (!run) begin
            ph_cnt <= '0;
            hi     <= 1'b0;
        end else if (!hi) begin
            if (ph_cnt == PW'(LO_CYC - 1)) begin
                ph_cnt <= '0;
                hi     <= 1'b1;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end else begin
            if (ph_cnt == PW'(HI_CYC - 1)) begin
                ph_cnt <= '0;
                hi     <= 1'b0;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign clk_o    = hi;
    assign slot_end = run && hi && (ph_cnt == PW'(HI_CYC - 1));

    // R11: the clock drops as soon as the engine is stopped
    p_clk_low_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !clk_o);
endmodule

// File: rtl/irx_cfg_master.sv
module irx_cfg_master
    import irx_pkg::*;
#(
    parameter int         HI_CYC     = 4,
    parameter int         LO_CYC     = 8,
    parameter int         POLL_MAX   = 10,
    parameter int         RST_PULSES = 30,
    parameter logic [7:0] INIT_ADDR  = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] op,
    input  logic [7:0] dev_addr,
    input  logic [6:0] reg_idx,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rdata,
    output logic       no_resp,
    output logic       cfg_clk,
    output logic       cfg_dout,
    input  logic       cfg_din
);
    localparam int CMAX = (RST_PULSES > POLL_MAX) ? RST_PULSES : POLL_MAX;
    localparam int CNTW = $clog2(CMAX + 8);
    localparam logic [2:0] LAST_STEP = 3'd4;

    irx_state_e    state;
    logic [CNTW-1:0] cnt;
    logic [7:0]    sh, rsh, cur_addr, cur_wd, mode_q;
    logic [6:0]    cur_idx;
    logic          cur_rd, in_init;
    logic [2:0]    step;
    logic          run, slot_end, din_s, sub_fin, dout_nx;
    logic [6:0]    nx_idx;
    logic [7:0]    nx_wd;
    logic          nx_rd;

    function automatic logic [7:0] cmd_byte(input logic [7:0] a, input logic [6:0] i,
                                            input logic rd);
        return a | {i, 1'b0} | {7'd0, ~rd};
    endfunction

    irx_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(cfg_din), .q(din_s));

    irx_pulse_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .run(run), .clk_o(cfg_clk), .slot_end(slot_end));

    assign run  = (state != S_IDLE) && (state != S_DONE);
    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    assign sub_fin = slot_end &&
        (((state == S_WTAIL) && (cnt == CNTW'(1))) ||
         ((state == S_RFIN)  && (cnt == CNTW'(2))) ||
         ((state == S_RST)   && (cnt == CNTW'(RST_PULSES - 1))));

    // next start-up step, selected by the step just finished
    always_comb begin
        nx_idx = 7'd0; nx_wd = 8'h17; nx_rd = 1'b0;
        unique case (step)
            3'd0:    begin nx_idx = 7'd0; nx_wd = 8'h17;  nx_rd = 1'b0; end
            3'd1:    begin nx_idx = 7'd1; nx_wd = mode_q; nx_rd = 1'b0; end
            3'd2:    begin nx_idx = 7'd2; nx_wd = 8'hFF;  nx_rd = 1'b0; end
            default: begin nx_idx = 7'd1; nx_wd = 8'h00;  nx_rd = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; cnt <= '0; sh <= '0; rsh <= '0;
            rdata <= '0; no_resp <= 1'b0; cur_rd <= 1'b0; cur_addr <= '0;
            cur_idx <= '0; cur_wd <= '0; in_init <= 1'b0; step <= '0; mode_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req) begin
                    cur_addr <= dev_addr; cur_idx <= reg_idx; cur_wd <= wdata;
                    mode_q <= wdata; cnt <= '0; step <= '0;
                    in_init <= (op == OP_INIT);
                    cur_rd  <= (op == OP_RD);
                    state   <= (op == OP_RST || op == OP_INIT) ? S_RST : S_START;
                end
                S_START: if (slot_end) begin
                    state <= S_CMD; cnt <= '0;
                    sh <= cmd_byte(cur_addr, cur_idx, cur_rd);
                end
                S_CMD, S_WDAT: if (slot_end) begin
                    cnt <= cnt + 1'b1;
                    sh  <= {1'b0, sh[7:1]};
                    if (cnt == CNTW'(7)) begin
                        cnt <= '0;
                        if (state == S_WDAT)  state <= S_WTAIL;
                        else if (cur_rd)      state <= S_POLL;
                        else begin state <= S_WDAT; sh <= cur_wd; end
                    end
                end
                S_POLL: if (slot_end) begin
                    cnt <= cnt + 1'b1;
                    if (!din_s) begin
                        state <= S_RDAT; cnt <= '0;
                    end else if (cnt == CNTW'(POLL_MAX - 1)) begin
                        state <= S_DUMMY; cnt <= '0;
                    end
                end
                S_RDAT: if (slot_end) begin
                    cnt <= cnt + 1'b1;
                    rsh <= {din_s, rsh[7:1]};
                    if (cnt == CNTW'(7)) begin
                        state <= S_REND; rdata <= {din_s, rsh[7:1]}; no_resp <= 1'b0;
                    end
                end
                S_DUMMY: if (slot_end) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNTW'(1)) begin
                        state <= S_REND; rdata <= 8'h00; no_resp <= 1'b1;
                    end
                end
                S_REND: if (slot_end) begin
                    state <= S_RFIN; cnt <= '0;
                end
                S_WTAIL, S_RFIN, S_RST: if (slot_end) begin
                    cnt <= cnt + 1'b1;
                    if (sub_fin) begin
                        if (in_init && step != LAST_STEP) begin
                            step <= step + 1'b1; cnt <= '0; state <= S_START;
                            cur_addr <= INIT_ADDR; cur_idx <= nx_idx;
                            cur_wd <= nx_wd; cur_rd <= nx_rd;
                        end else begin
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_CMD, S_WDAT:                     dout_nx = sh[0];
            S_POLL, S_RDAT, S_DUMMY, S_REND:   dout_nx = 1'b1;
            default:                           dout_nx = 1'b0;
        endcase
    end

    // data register: updates one cycle into the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_dout <= 1'b0;
        else        cfg_dout <= dout_nx;
    end

    p_dout_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_idle_lines_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cfg_clk && !cfg_dout));
    p_nack_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_resp) |-> (rdata == 8'h00));
    p_reset_data_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RST && $past(state == S_RST)) |-> !cfg_dout);
endmodule

// File: tb/sim_irx_cfg_master.sv
`timescale 1ns/1ps
module sim_irx_cfg_master;
    localparam int HI = 4;
    localparam int LO = 8;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] dev_addr = 8'h00, wdata = 8'h00;
    logic [6:0] reg_idx = 7'd0;
    logic busy, done, no_resp, cfg_clk, cfg_dout;
    logic [7:0] rdata;
    logic din = 1'b1;

    always #2.5 clk = ~clk;

    irx_cfg_master #(.HI_CYC(HI), .LO_CYC(LO)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .dev_addr(dev_addr),
        .reg_idx(reg_idx), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .no_resp(no_resp), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .cfg_din(din));

    typedef struct {
        string      tag;
        int         npulse;
        logic [7:0] rd;
        logic       nk;
        bit         chk_rd;
    } exp_t;

    exp_t exp_q[$];
    bit   exp_bits[$];
    int   n_chk = 0, n_bad = 0;
    int   pc = 0, ready_at = 0, frame_err = 0, width_err = 0;
    logic [7:0] resp_byte = 8'h00;
    bit   finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // module model plus waveform scoreboard at each rising config clock
    always @(posedge cfg_clk) begin
        pc = pc + 1;
        if (exp_bits.size() == 0) frame_err++;
        else if (exp_bits.pop_front() !== cfg_dout) frame_err++;
        if (ready_at != 0 && pc == ready_at) din = 1'b0;
        else if (ready_at != 0 && pc > ready_at && pc <= ready_at + 8)
            din = resp_byte[pc - ready_at - 1];
        else din = 1'b1;
    end

    // phase width monitor (R12)
    int hi_run = 0, lo_run = 0;
    bit seen_fall = 0;
    logic prev_clk = 1'b0;
    always @(negedge clk) begin
        if (!busy) begin seen_fall = 0; lo_run = 0; end
        if (cfg_clk) begin
            if (!prev_clk && seen_fall && lo_run != LO) width_err++;
            hi_run++;
        end else begin
            if (prev_clk) begin
                if (hi_run != HI) width_err++;
                hi_run = 0; lo_run = 0; seen_fall = 1;
            end
            lo_run++;
        end
        prev_clk = cfg_clk;
    end

    // result monitor: pops one expected item per done
    always @(negedge clk) begin
        if (done) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                check(0, "R10", "unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(frame_err == 0, e.tag, "waveform bit errors", frame_err, 0);
                check(pc == e.npulse, e.tag, "pulse count", pc, e.npulse);
                check(width_err == 0, "R12", "phase width errors", width_err, 0);
                if (e.chk_rd) begin
                    check(rdata == e.rd, e.tag, "rdata", rdata, e.rd);
                    check(no_resp == e.nk, e.tag, "no_resp", no_resp, e.nk);
                end
            end
            frame_err = 0; width_err = 0;
        end
    end

    function automatic logic [7:0] cmd(input logic [7:0] a, input logic [6:0] i,
                                       input bit wr);
        return a | (8'(i) << 1) | (wr ? 8'h01 : 8'h00);
    endfunction

    task automatic push_n(input bit v, input int n);
        for (int k = 0; k < n; k++) exp_bits.push_back(v);
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int k = 0; k < 8; k++) exp_bits.push_back(b[k]);
    endtask

    task automatic exp_write(input logic [7:0] a, input logic [6:0] i, input logic [7:0] d);
        push_n(0, 1); push_byte(cmd(a, i, 1)); push_byte(d); push_n(0, 2);
    endtask

    task automatic exp_read(input logic [7:0] a, input logic [6:0] i, input int polls);
        push_n(0, 1); push_byte(cmd(a, i, 0));
        if (polls > 0) begin push_n(1, polls); push_n(1, 8); end
        else begin push_n(1, 10); push_n(1, 2); end
        push_n(1, 1); push_n(0, 3);
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [6:0] i,
                          input logic [7:0] d, input int rdy, input logic [7:0] rb,
                          input string tag, input logic [7:0] erd, input logic enk,
                          input bit chk, input bit poke);
        exp_t e;
        e.tag = tag; e.npulse = exp_bits.size(); e.rd = erd; e.nk = enk; e.chk_rd = chk;
        exp_q.push_back(e);
        pc = 0; ready_at = rdy; resp_byte = rb;
        @(negedge clk);
        op = o; dev_addr = a; reg_idx = i; wdata = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R10", "busy after request", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            op = 2'd2; dev_addr = 8'hFF; wdata = 8'hFF; req = 1'b1;   // R10 ignored request
            @(negedge clk);
            req = 1'b0;
        end
        while (busy) @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle only", done, 0);
        check(!cfg_clk && !cfg_dout, "R11", "idle lines", {cfg_clk, cfg_dout}, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        check(0, "WATCHDOG", "timeout", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R11", "reset busy/done", {busy, done}, 0);
        check(!cfg_clk && !cfg_dout, "R11", "reset lines", {cfg_clk, cfg_dout}, 0);
        check(rdata == 8'h00 && !no_resp, "R11", "reset result", {no_resp, rdata}, 0);

        // R1 R3: writes with two command patterns
        exp_write(8'h40, 7'd3, 8'hA5);
        run_op(2'd0, 8'h40, 7'd3, 8'hA5, 0, 8'h00, "R3", 8'h00, 0, 0, 0);
        exp_write(8'h00, 7'h55, 8'h3C);
        run_op(2'd0, 8'h00, 7'h55, 8'h3C, 0, 8'h00, "R1", 8'h00, 0, 0, 0);

        // R4 R5 R7: read ready at first poll
        exp_read(8'h40, 7'd1, 1);
        run_op(2'd1, 8'h40, 7'd1, 8'h00, 9 + 1, 8'h96, "R5", 8'h96, 0, 1, 0);
        // R4: ready at last allowed poll
        exp_read(8'h22, 7'd7, 10);
        run_op(2'd1, 8'h22, 7'd7, 8'h00, 9 + 10, 8'h01, "R4", 8'h01, 0, 1, 0);
        // R6: no reply
        exp_read(8'h40, 7'd2, 0);
        run_op(2'd1, 8'h40, 7'd2, 8'h00, 0, 8'hFF, "R6", 8'h00, 1, 1, 0);
        // R5 R7: flag cleared by a good read
        exp_read(8'h10, 7'd4, 4);
        run_op(2'd1, 8'h10, 7'd4, 8'h00, 9 + 4, 8'hC3, "R7", 8'hC3, 0, 1, 0);
        // R8: reset burst
        push_n(0, 30);
        run_op(2'd2, 8'h00, 7'd0, 8'h00, 0, 8'h00, "R8", 8'h00, 0, 0, 0);
        // R10: request during a write is ignored
        exp_write(8'h40, 7'd5, 8'h69);
        run_op(2'd0, 8'h40, 7'd5, 8'h69, 0, 8'h00, "R10", 8'h00, 0, 0, 1);
        // R9: start-up sequence
        push_n(0, 30);
        exp_write(8'h40, 7'd0, 8'h17);
        exp_write(8'h40, 7'd1, 8'h2D);
        exp_write(8'h40, 7'd2, 8'hFF);
        exp_read(8'h40, 7'd1, 2);
        run_op(2'd3, 8'h00, 7'd0, 8'h2D, 30 + 57 + 9 + 2, 8'h5A, "R9", 8'h5A, 0, 1, 0);

        check(exp_q.size() == 0, "R10", "missing done count", exp_q.size(), 0);
        report();
    end
endmodule